// File: doc/BRIEF.md
# Windowed Single-Shot DMA Engine

This block copies a run of bytes between host memory and a 4 KiB on-chip buffer. The buffer is seen by software as a fixed window in the device address space. Software loads a source address, a destination address and a byte count through a 64-bit register port. It then writes a command word with the run bit set. After a fixed, parameterised number of cycles the engine checks the local range and moves the bytes one at a time over a byte-wide request/acknowledge host port. When it finishes, it drops the run bit and can raise an interrupt bit.

The direction bit selects which address register refers to the local window. With direction 0 the engine reads host memory at the source address and fills the buffer at the destination address. With direction 1 it reads the buffer at the source address and writes host memory at the destination address. Host addresses are masked to a configurable number of low bits. A local range that does not fit the window is not performed. Instead it sets an error output and ends the command at once.

Top module: `win_dma`

## Requirements
- R1: After reset, busy, err and irq_vec are 0, and the source (0x80), destination (0x88), count (0x90) and command (0x98) registers all read 0.
- R2: The four registers sit at offsets 0x80, 0x88, 0x90 and 0x98. A wide access (reg_wide=1) moves all 64 bits. A narrow access (reg_wide=0) writes the low 32 bits of reg_wdata with the upper half zeroed, and reads the low 32 bits zero-extended. A read of any other offset returns all ones.
- R3: A command write whose bit 0 (run) is 0 is ignored entirely. A command write with bit 0 set, accepted while idle, stores the word and raises busy from the next cycle. busy reads as command bit 0, and the host port requests only while busy.
- R4: While busy, writes to all four registers are ignored.
- R5: The first host request appears exactly DELAY+1 clock edges after the edge that accepts the command.
- R6: With command bit 1 = 0, byte i is read from host address src+i and stored at buffer offset dst-0x40000+i, for i from 0 to count-1.
- R7: With command bit 1 = 1, buffer offset src-0x40000+i is written to host address dst+i.
- R8: Every host address is (register + i) ANDed with a mask of the low HMASK_BITS bits (default 28, 0x0FFFFFFF), so the address wraps inside the masked space.
- R9: The local range [L, L+count) is accepted only if 0x40000 <= L < 0x41000, L+count > L and L+count < 0x41000 (a range ending exactly at the last byte is rejected). A rejected range sets err, issues no host request and ends the command.
- R10: At the end of a command, including a rejected one, bit 0 of the command register clears and busy falls. If command bit 2 was set, irq_vec bit 8 is set.
- R11: A write to offset 0x64 clears the irq_vec bits that are 1 in the low 32 bits of the data, whether or not the engine is busy. err stays set until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| hst_req | output | 1 | Host byte request, held until acknowledged |
| hst_we | output | 1 | 1 = host write, 0 = host read |
| hst_addr | output | 64 | Masked host byte address |
| hst_wdata | output | 8 | Byte to write to host |
| hst_ack | input | 1 | Host acknowledge; read data is valid in the same cycle |
| hst_rdata | input | 8 | Byte read from host |
| busy | output | 1 | A command is pending or running |
| err | output | 1 | The last command had a rejected local range |
| irq_vec | output | 32 | Interrupt vector; bit 8 marks completion |

## Verification
Most internal faults reach the host port at once. A wrong index or offset shows as a wrong host address or byte in the same cycle. A miscounted transfer ends one acknowledge early or late, and a broken lock alters a register that software can read back before the next command. The delay counter is checked exactly, by counting edges to the first request. Range-check mistakes show up at the window edges: one byte inside versus at the end, a start just below the base, and a zero count. Each of these either lights err with no host traffic or performs the copy. A lost completion leaves busy stuck, which the polling timeout reports.

// File: rtl/win_dma_pkg.sv
package win_dma_pkg;
  localparam int REG_W = 64;

  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;
  localparam logic [7:0] OFS_ACK = 8'h64;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;
  localparam int IRQ_DONE_BIT = 8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_MOVE, SQ_END} seq_e;

  // local range [lcl, lcl+cnt) must start in window, be non-empty,
  // and end strictly before the window's end
  function automatic logic range_ok(input logic [REG_W-1:0] lcl,
                                    input logic [REG_W-1:0] cnt,
                                    input logic [REG_W-1:0] base,
                                    input logic [REG_W-1:0] size);
    logic [REG_W:0] fin_a;
    logic [REG_W:0] wend;
    fin_a = {1'b0, lcl} + {1'b0, cnt};
    wend  = {1'b0, base} + {1'b0, size};
    return (lcl >= base) && ({1'b0, lcl} < wend) &&
           (fin_a > {1'b0, lcl}) && (fin_a < wend);
  endfunction

  function automatic logic [REG_W-1:0] host_at(input logic [REG_W-1:0] start,
                                               input logic [REG_W-1:0] step,
                                               input logic [REG_W-1:0] mask);
    return (start + step) & mask;
  endfunction
endpackage

// File: rtl/win_dma_regs.sv
module win_dma_regs
  import win_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_wide,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fin,
  output logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] dst_q,
  output logic [REG_W-1:0] cnt_q,
  output logic [REG_W-1:0] cmd_q,
  output logic             go,
  output logic [31:0]      irq_vec
);
  logic [REG_W-1:0] wv;
  logic [REG_W-1:0] rv;
  logic             run;

  assign run = cmd_q[CMD_RUN];
  assign wv  = reg_wide ? reg_wdata : {32'b0, reg_wdata[31:0]};
  assign go  = reg_wr && !run && (reg_addr == OFS_CMD) && wv[CMD_RUN];

  always_comb begin
    case (reg_addr)
      OFS_SRC: rv = src_q;
      OFS_DST: rv = dst_q;
      OFS_CNT: rv = cnt_q;
      OFS_CMD: rv = cmd_q;
      default: rv = '1;
    endcase
    reg_rdata = reg_wide ? rv : {32'b0, rv[31:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      cmd_q   <= '0;
      irq_vec <= '0;
    end else begin
      if (reg_wr && !run) begin
        case (reg_addr)
          OFS_SRC: src_q <= wv;
          OFS_DST: dst_q <= wv;
          OFS_CNT: cnt_q <= wv;
          OFS_CMD: if (wv[CMD_RUN]) cmd_q <= wv;
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == OFS_ACK) irq_vec <= irq_vec & ~wv[31:0];
      if (fin) begin
        cmd_q[CMD_RUN] <= 1'b0;
        if (cmd_q[CMD_IRQ]) irq_vec[IRQ_DONE_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/win_dma_buf.sv
module win_dma_buf #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/win_dma_seq.sv
module win_dma_seq
  import win_dma_pkg::*;
#(
  parameter int               DELAY    = 16,
  parameter logic [REG_W-1:0] WIN_BASE = 64'h40000,
  parameter int               WIN_SIZE = 4096,
  parameter logic [REG_W-1:0] MASK     = 64'h0FFF_FFFF,
  localparam int AW  = $clog2(WIN_SIZE),
  localparam int IW  = AW + 1,
  localparam int DLW = $clog2(DELAY + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             dir,
  input  logic [REG_W-1:0] src_q,
  input  logic [REG_W-1:0] dst_q,
  input  logic [REG_W-1:0] cnt_q,
  output logic             hst_req,
  output logic             hst_we,
  output logic [REG_W-1:0] hst_addr,
  input  logic             hst_ack,
  output logic             buf_we,
  output logic [AW-1:0]    buf_idx,
  output logic             fin,
  output logic             range_bad,
  output logic             err
);
  seq_e             state;
  logic [DLW-1:0]   dly;
  logic [IW-1:0]    idx;
  logic [REG_W-1:0] lcl;
  logic [REG_W-1:0] hbase;
  logic [REG_W-1:0] lofs;
  logic             last;

  assign lcl       = dir ? src_q : dst_q;
  assign hbase     = dir ? dst_q : src_q;
  assign lofs      = lcl - WIN_BASE;
  assign buf_idx   = lofs[AW-1:0] + idx[AW-1:0];
  assign hst_req   = (state == SQ_MOVE);
  assign hst_we    = dir;
  assign hst_addr  = host_at(hbase, {{(REG_W-IW){1'b0}}, idx}, MASK);
  assign buf_we    = hst_req && hst_ack && !dir;
  assign fin       = (state == SQ_END);
  assign range_bad = (state == SQ_WAIT) && (dly == '0) &&
                     !range_ok(lcl, cnt_q, WIN_BASE, REG_W'(WIN_SIZE));
  assign last      = ({{(REG_W-IW){1'b0}}, idx} + 1'b1) == cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      dly   <= '0;
      idx   <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          state <= SQ_WAIT;
          dly   <= DLW'(DELAY);
          idx   <= '0;
          err   <= 1'b0;
        end
        SQ_WAIT: begin
          if (dly != '0) dly <= dly - 1'b1;
          else if (range_bad) begin
            err   <= 1'b1;
            state <= SQ_END;
          end else state <= SQ_MOVE;
        end
        SQ_MOVE: if (hst_ack) begin
          idx <= idx + 1'b1;
          if (last) state <= SQ_END;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_dma.sv
module win_dma
  import win_dma_pkg::*;
#(
  parameter int               DELAY      = 16,
  parameter logic [REG_W-1:0] WIN_BASE   = 64'h40000,
  parameter int               WIN_SIZE   = 4096,
  parameter int               HMASK_BITS = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        hst_req,
  output logic        hst_we,
  output logic [63:0] hst_addr,
  output logic [7:0]  hst_wdata,
  input  logic        hst_ack,
  input  logic [7:0]  hst_rdata,
  output logic        busy,
  output logic        err,
  output logic [31:0] irq_vec
);
  localparam int               AW   = $clog2(WIN_SIZE);
  localparam logic [REG_W-1:0] MASK = (REG_W'(1) << HMASK_BITS) - 1;

  logic [REG_W-1:0] src_q, dst_q, cnt_q, cmd_q;
  logic             go, fin, buf_we, range_bad;
  logic [AW-1:0]    buf_idx;

  win_dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fin(fin), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cmd_q(cmd_q),
    .go(go), .irq_vec(irq_vec)
  );

  win_dma_seq #(
    .DELAY(DELAY), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .MASK(MASK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .dir(cmd_q[CMD_DIR]),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_ack(hst_ack),
    .buf_we(buf_we), .buf_idx(buf_idx), .fin(fin), .range_bad(range_bad),
    .err(err)
  );

  win_dma_buf #(.DEPTH(WIN_SIZE)) u_buf (
    .clk(clk), .we(buf_we), .idx(buf_idx), .wdata(hst_rdata),
    .rdata(hst_wdata)
  );

  assign busy = cmd_q[CMD_RUN];
endmodule

// File: rtl/win_dma_chk.sv
module win_dma_chk
  import win_dma_pkg::*;
#(
  parameter int               DELAY = 16,
  parameter logic [REG_W-1:0] MASK  = 64'h0FFF_FFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [7:0]       reg_addr,
  input logic             hst_req,
  input logic [63:0]      hst_addr,
  input logic             busy,
  input logic             err,
  input logic [31:0]      irq_vec,
  input logic             go,
  input logic             fin,
  input logic             range_bad,
  input logic [REG_W-1:0] src_q,
  input logic [REG_W-1:0] cnt_q,
  input logic [REG_W-1:0] cmd_q
);
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (go) gap <= '0;
    else if (gap <= 32'(DELAY)) gap <= gap + 1'b1;
  end

  assert_req_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req |-> busy);
  assert_lock_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == OFS_SRC) |=> $stable(src_q));
  assert_lock_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == OFS_CNT) |=> $stable(cnt_q));
  assert_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req |-> gap >= 32'(DELAY));
  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req |-> ((hst_addr & ~MASK) == '0));
  assert_bad_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    range_bad |=> (err && !hst_req));
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !hst_req);
  assert_fin_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_vec[IRQ_DONE_BIT]) |-> $past(fin && cmd_q[CMD_IRQ]));
endmodule

bind win_dma win_dma_chk #(.DELAY(DELAY), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .hst_req(hst_req), .hst_addr(hst_addr), .busy(busy), .err(err),
  .irq_vec(irq_vec), .go(go), .fin(fin), .range_bad(range_bad),
  .src_q(src_q), .cnt_q(cnt_q), .cmd_q(cmd_q)
);

// File: tb/win_dma_test.sv
module win_dma_test;
  localparam int          DLY  = 5;
  localparam logic [63:0] WB   = 64'h40000;
  localparam logic [63:0] HMSK = 64'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wide = 1'b1;
  logic [7:0]  reg_addr = 8'h0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        hst_req, hst_we, hst_ack = 1'b0;
  logic [63:0] hst_addr;
  logic [7:0]  hst_wdata, hst_rdata = 8'h0;
  logic        busy, err;
  logic [31:0] irq_vec;

  int n_chk = 0, n_bad = 0, n_req = 0;
  logic [63:0] first_addr, last_addr;
  logic [7:0]  hmem [256];

  win_dma #(.DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .busy(busy), .err(err), .irq_vec(irq_vec)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [63:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // host memory model: acknowledges every other cycle
  always @(negedge clk) begin
    if (hst_req && !hst_ack) begin
      hst_ack <= 1'b1;
      hst_rdata <= pat(hst_addr);
      if (n_req == 0) first_addr <= hst_addr;
      last_addr <= hst_addr;
      n_req <= n_req + 1;
      if (hst_we) hmem[hst_addr[7:0]] <= hst_wdata;
    end else hst_ack <= 1'b0;
  end

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic wide, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a; reg_wide = wide;
    #1 v = reg_rdata;
    reg_wide = 1'b1;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    check(!busy, tag, 64'(busy), 64'd0);
  endtask

  task automatic setup(input logic [63:0] s, input logic [63:0] d,
                       input logic [63:0] c);
    wr(8'h80, s, 1'b1);
    wr(8'h88, d, 1'b1);
    wr(8'h90, c, 1'b1);
    n_req = 0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check(!busy && !err, "R1 busy/err", {err, busy}, 64'd0);
    check(irq_vec == 0, "R1 irq", 64'(irq_vec), 64'd0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(i * 8), 1'b1, v);
      check(v == 0, "R1 reg", v, 64'd0);
    end
  endtask

  task automatic t_regs();
    logic [63:0] v;
    wr(8'h88, 64'h1122_3344_5566_7788, 1'b1);
    rd(8'h88, 1'b1, v);
    check(v == 64'h1122_3344_5566_7788, "R2 wide", v, 64'h1122_3344_5566_7788);
    rd(8'h88, 1'b0, v);
    check(v == 64'h5566_7788, "R2 narrow read", v, 64'h5566_7788);
    wr(8'h90, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    rd(8'h90, 1'b1, v);
    check(v == 64'hCCCC_DDDD, "R2 narrow write", v, 64'hCCCC_DDDD);
    rd(8'h30, 1'b1, v);
    check(v == '1, "R2 unmapped", v, '1);
  endtask

  task automatic t_norun();
    logic [63:0] v;
    wr(8'h98, 64'h6, 1'b1);
    @(negedge clk);
    check(!busy, "R3 no run busy", 64'(busy), 64'd0);
    rd(8'h98, 1'b1, v);
    check(v == 0, "R3 no run cmd", v, 64'd0);
  endtask

  task automatic t_dir0_delay();
    int n = 0;
    logic [63:0] v;
    setup(64'hF123_4000, WB + 64'h10, 64'd16);
    wr(8'h98, 64'h5, 1'b1);
    check(busy, "R3 busy", 64'(busy), 64'd1);
    while (!hst_req && n < 100) begin @(negedge clk); n++; end
    check(n == DLY + 1, "R5 delay", 64'(n), 64'(DLY + 1));
    wait_idle("R10 idle dir0");
    check(n_req == 16, "R6 count", 64'(n_req), 64'd16);
    check(first_addr == 64'h0123_4000, "R8 mask", first_addr, 64'h0123_4000);
    check(last_addr == 64'h0123_400F, "R6 last", last_addr, 64'h0123_400F);
    check(irq_vec == 32'h100, "R10 irq", 64'(irq_vec), 64'h100);
    check(!err, "R9 ok err", 64'(err), 64'd0);
    rd(8'h98, 1'b1, v);
    check(v == 64'h4, "R10 run clear", v, 64'h4);
    wr(8'h64, 64'h100, 1'b0);
    check(irq_vec == 0, "R11 ack", 64'(irq_vec), 64'd0);
  endtask

  task automatic t_dir1();
    setup(WB + 64'h10, 64'h2000, 64'd16);
    wr(8'h98, 64'h3, 1'b1);
    wait_idle("R10 idle dir1");
    check(first_addr == 64'h2000, "R7 addr", first_addr, 64'h2000);
    check(n_req == 16, "R7 count", 64'(n_req), 64'd16);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = pat(64'h0123_4000 + 64'(i));
      check(hmem[8'(i)] == e, "R7 data", 64'(hmem[8'(i)]), 64'(e));
    end
    check(irq_vec == 0, "R10 no irq", 64'(irq_vec), 64'd0);
  endtask

  task automatic t_wrap();
    setup(64'h0FFF_FFFE, WB, 64'd4);
    wr(8'h98, 64'h1, 1'b1);
    wait_idle("R8 idle");
    check(last_addr == 64'h1, "R8 wrap", last_addr, 64'h1);
  endtask

  task automatic t_lock();
    logic [63:0] v;
    setup(64'h100, WB, 64'd40);
    wr(8'h98, 64'h1, 1'b1);
    wr(8'h80, 64'h777, 1'b1);
    wr(8'h90, 64'h3, 1'b1);
    wr(8'h98, 64'h7, 1'b1);
    wait_idle("R4 idle");
    rd(8'h80, 1'b1, v);
    check(v == 64'h100, "R4 src", v, 64'h100);
    rd(8'h90, 1'b1, v);
    check(v == 64'd40, "R4 cnt", v, 64'd40);
    rd(8'h98, 1'b1, v);
    check(v == 64'h0, "R4 cmd", v, 64'h0);
    check(n_req == 40, "R4 len", 64'(n_req), 64'd40);
  endtask

  task automatic t_range(input logic [63:0] d, input logic [63:0] c,
                         input logic bad, input string tag);
    setup(64'h300, d, c);
    wr(8'h98, 64'h5, 1'b1);
    wait_idle(tag);
    check(err == bad, tag, 64'(err), 64'(bad));
    check(n_req == (bad ? 0 : int'(c)), tag, 64'(n_req), bad ? 64'd0 : c);
    check(irq_vec == 32'h100, "R10 irq range", 64'(irq_vec), 64'h100);
    wr(8'h64, 64'hFFFF_FFFF, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_norun();
        t_dir0_delay();
        t_dir1();
        t_wrap();
        t_lock();
        t_range(WB - 1, 64'd4, 1'b1, "R9 below");
        t_range(WB + 64'hFF0, 64'd16, 1'b1, "R9 end at edge");
        t_range(WB + 64'hFEF, 64'd16, 1'b0, "R9 last inside");
        t_range(WB + 64'h20, 64'd0, 1'b1, "R9 zero count");
        t_range(WB + 64'h20, 64'd8, 1'b0, "R11 err clears");
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule